// File: doc/BRIEF.md
# Antenna Auto-Tune Sequencer

This block drives the search that brings an antenna into match through a 30-relay L-network. After a start pulse it loads a starting relay word and sends it to four cascaded 8-bit latching relay drivers over a serial link. It then waits a fixed settling time and reads two impedance detector flags. A magnitude flag steers the inductor field and a phase flag steers the capacitor field. The two fields take turns, and every step moves one of them by one count. After every step the new word goes out to the drivers again.

The search ends in one of two ways. It succeeds when the SWR detector reports a ratio below 1.1. It fails when both detector flags have flipped with no match, when the step budget is used up, or when a field would have to move past its end. While the search runs, the block holds a transmit request high. When the exciter drive is outside its window, the search pauses with a code that tells the operator to raise or lower the drive. On success it gives a one-clock pulse that tells the surrounding logic to store the word as a preset.

Top module: `antenna_tune_seq`

## Requirements
- R1: The block leaves its idle, done or failed state only when `start_i` is high. It then loads `preset_i` into `relay_word_o` and sends it to the drivers. `status_o` reads 1 (searching) and `tx_req_o` is high for as long as the search is active.
- R2: Each relay update is sent as a 32-bit frame, most significant bit first. The top two frame bits are 0 and frame bits 29:0 equal the relay word. Each bit is held for two clocks and `ser_clk_o` is high on the second of them. `ser_latch_o` pulses for one clock, one clock after the last bit. `ser_oe_o` goes high after the first latch pulse and stays high.
- R3: The steps alternate, beginning with the inductor field (word bits 29:15) and then the capacitor field (bits 14:0). `imp_low_i` = 0 (above 50 Ω) raises the inductor by one and `imp_low_i` = 1 lowers it by one. `cur_lead_i` = 1 (current leads) lowers the capacitor by one and `cur_lead_i` = 0 raises it by one. No other bit of the word changes.
- R4: The flags are read only after the settle time that follows each frame. If `drive_low_i` is high at that read, the search pauses with `status_o` = 2. If `drive_high_i` is high and `drive_low_i` is low, it pauses with `status_o` = 3. The relay word is frozen during the pause, and the search resumes with a fresh settle once both drive flags are low.
- R5: If `swr_ok_i` is high at a read (and the drive is within its window), `status_o` becomes 5. `store_o` then pulses high for exactly one clock and `tx_req_o` drops.
- R6: If both `imp_low_i` and `cur_lead_i` differ from the values seen at the first read of the run, and `swr_ok_i` is low, the search fails with `status_o` = 4 and no `store_o` pulse.
- R7: Once STEP_MAX steps have been taken, the next read that does not succeed fails the search with `status_o` = 4.
- R8: A step that would raise a field that is all ones, or lower a field that is zero, fails the search with `status_o` = 4 and leaves the word unchanged.
- R9: After reset, `status_o` is 0 and the relay word, `tx_req_o`, `store_o`, `ser_latch_o`, `ser_clk_o` and `ser_oe_o` are all 0.
- R10: `start_i` has no effect while a search is active, including while it is paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search |
| preset_i | input | 30 | Starting relay word |
| imp_low_i | input | 1 | 1 = impedance below 50 Ω, 0 = above |
| cur_lead_i | input | 1 | 1 = current leads voltage |
| swr_ok_i | input | 1 | SWR below 1.1 |
| drive_low_i | input | 1 | Exciter drive too weak |
| drive_high_i | input | 1 | Exciter drive too strong |
| relay_word_o | output | 30 | Current relay word, inductor field in bits 29:15 and capacitor field in bits 14:0 |
| ser_data_o | output | 1 | Serial data to the relay drivers |
| ser_clk_o | output | 1 | Serial shift clock |
| ser_latch_o | output | 1 | Latch strobe |
| ser_oe_o | output | 1 | Driver output enable |
| tx_req_o | output | 1 | Transmit request to the exciter |
| status_o | output | 3 | 0 idle, 1 searching, 2 drive low, 3 drive high, 4 failed, 5 tuned |
| store_o | output | 1 | One-clock pulse to save the word as a preset |

## Verification
`relay_word_o` changes on the clock edge that ends a read. The frame for that word follows over the next 64 clocks, and the latch comes in the 65th. The next read falls SETTLE_CYC clocks after the latch. `status_o`, `tx_req_o` and `store_o` follow the state with no extra delay.

Because of this timing, the bench does not pin results to fixed cycle numbers. On every falling edge it compares each change of the word against a queue of words that a behavioural model predicts from the preset and a simple antenna model. It rebuilds each frame from the serial pins and compares it at the latch. The final status and the count of store pulses are checked once the search settles in the done or failed state.

// File: rtl/atune_pkg.sv
package atune_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT, S_SETTLE, S_EVAL, S_PAUSE, S_DONE, S_FAIL
  } fsm_e;

  typedef enum logic [2:0] {
    CODE_IDLE = 3'd0,
    CODE_BUSY = 3'd1,
    CODE_LOW  = 3'd2,
    CODE_HIGH = 3'd3,
    CODE_FAIL = 3'd4,
    CODE_DONE = 3'd5
  } code_e;

  typedef enum logic {AX_IND = 1'b0, AX_CAP = 1'b1} axis_e;
endpackage

// File: rtl/atune_step.sv
// One-count move of a relay field, with end-of-range detection.
module atune_step #(
  parameter int W = 15
) (
  input  logic [W-1:0] val_i,
  input  logic         dir_up_i,
  output logic [W-1:0] nxt_o,
  output logic         at_end_o
);
  always_comb begin
    if (dir_up_i) begin
      nxt_o    = val_i + W'(1);
      at_end_o = &val_i;
    end else begin
      nxt_o    = val_i - W'(1);
      at_end_o = ~|val_i;
    end
  end
endmodule

// File: rtl/atune_ser.sv
// Frame shifter: MSB first, two clocks per bit, latch one clock after the last bit.
module atune_ser #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdat_o,
  output logic               sclk_o,
  output logic               latch_o,
  output logic               oe_o,
  output logic               busy_o
);
  localparam int CW = $clog2(2 * FRAME_W + 1);
  localparam logic [CW-1:0] LAST = CW'(2 * FRAME_W);

  logic               busy_q, busy_d;
  logic               oe_q, oe_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [FRAME_W-1:0] sr_q, sr_d;

  always_comb begin
    busy_d = busy_q;
    oe_d   = oe_q;
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    if (go_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      sr_d   = frame_i;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        oe_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q[0]) sr_d = {sr_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else begin
      busy_q <= busy_d;
      oe_q   <= oe_d;
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
    end
  end

  assign sdat_o  = busy_q & sr_q[FRAME_W-1];
  assign sclk_o  = busy_q & cnt_q[0];
  assign latch_o = busy_q & (cnt_q == LAST);
  assign oe_o    = oe_q;
  assign busy_o  = busy_q;

  // R2: the latch strobe follows directly on the last shift clock
  p_latch_after_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> $past(sclk_o));
  // R2: once enabled, the drivers stay enabled
  p_oe_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_o) |-> oe_o);
endmodule

// File: rtl/atune_ctrl.sv
module atune_ctrl
  import atune_pkg::*;
#(
  parameter int L_W        = 15,
  parameter int C_W        = 15,
  parameter int SETTLE_CYC = 8,
  parameter int STEP_MAX   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [L_W+C_W-1:0] preset_i,
  input  logic               imp_low_i,
  input  logic               cur_lead_i,
  input  logic               swr_ok_i,
  input  logic               drv_low_i,
  input  logic               drv_high_i,
  input  logic               ser_latch_i,
  output logic               ser_go_o,
  output logic [L_W+C_W-1:0] relay_nxt_o,
  output logic [L_W+C_W-1:0] relay_o,
  output logic               tx_req_o,
  output logic [2:0]         status_o,
  output logic               store_o
);
  localparam int R_W = L_W + C_W;
  localparam int SW  = $clog2(STEP_MAX + 1);
  localparam int TW  = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [SW-1:0] STEP_LIM  = SW'(STEP_MAX);

  fsm_e           st_q, st_d;
  axis_e          axis_q, axis_d;
  logic [R_W-1:0] relay_q, relay_d;
  logic [SW-1:0]  steps_q, steps_d;
  logic [TW-1:0]  settle_q, settle_d;
  logic           first_q, first_d;
  logic           ref_mag_q, ref_mag_d, ref_lead_q, ref_lead_d;
  logic           hi_q, hi_d;
  logic           store_q, store_d;

  logic [L_W-1:0] ind_nxt;
  logic [C_W-1:0] cap_nxt;
  logic           ind_end, cap_end, drive_bad, flipped;

  atune_step #(.W(L_W)) u_ind (
    .val_i(relay_q[R_W-1:C_W]), .dir_up_i(~imp_low_i),
    .nxt_o(ind_nxt), .at_end_o(ind_end));

  atune_step #(.W(C_W)) u_cap (
    .val_i(relay_q[C_W-1:0]), .dir_up_i(~cur_lead_i),
    .nxt_o(cap_nxt), .at_end_o(cap_end));

  assign drive_bad = drv_low_i | drv_high_i;
  assign flipped   = !first_q && (imp_low_i != ref_mag_q) && (cur_lead_i != ref_lead_q);

  always_comb begin
    st_d       = st_q;
    axis_d     = axis_q;
    relay_d    = relay_q;
    steps_d    = steps_q;
    settle_d   = settle_q;
    first_d    = first_q;
    ref_mag_d  = ref_mag_q;
    ref_lead_d = ref_lead_q;
    hi_d       = hi_q;
    store_d    = 1'b0;
    ser_go_o   = 1'b0;
    unique case (st_q)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start_i) begin
          relay_d  = preset_i;
          axis_d   = AX_IND;
          steps_d  = '0;
          first_d  = 1'b1;
          ser_go_o = 1'b1;
          st_d     = S_SHIFT;
        end
      end
      S_SHIFT: begin
        if (ser_latch_i) begin
          settle_d = SETTLE_LD;
          st_d     = S_SETTLE;
        end
      end
      S_SETTLE: begin
        if (settle_q == '0) st_d = S_EVAL;
        else settle_d = settle_q - TW'(1);
      end
      S_EVAL: begin
        if (drive_bad) begin
          hi_d = !drv_low_i;
          st_d = S_PAUSE;
        end else if (swr_ok_i) begin
          store_d = 1'b1;
          st_d    = S_DONE;
        end else if (flipped || steps_q == STEP_LIM) begin
          st_d = S_FAIL;
        end else if ((axis_q == AX_IND) ? ind_end : cap_end) begin
          st_d = S_FAIL;
        end else begin
          if (first_q) begin
            ref_mag_d  = imp_low_i;
            ref_lead_d = cur_lead_i;
            first_d    = 1'b0;
          end
          if (axis_q == AX_IND) begin
            relay_d[R_W-1:C_W] = ind_nxt;
            axis_d             = AX_CAP;
          end else begin
            relay_d[C_W-1:0] = cap_nxt;
            axis_d           = AX_IND;
          end
          steps_d  = steps_q + SW'(1);
          ser_go_o = 1'b1;
          st_d     = S_SHIFT;
        end
      end
      S_PAUSE: begin
        if (!drive_bad) begin
          settle_d = SETTLE_LD;
          st_d     = S_SETTLE;
        end else begin
          hi_d = !drv_low_i;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      axis_q     <= AX_IND;
      relay_q    <= '0;
      steps_q    <= '0;
      settle_q   <= '0;
      first_q    <= 1'b1;
      ref_mag_q  <= 1'b0;
      ref_lead_q <= 1'b0;
      hi_q       <= 1'b0;
      store_q    <= 1'b0;
    end else begin
      st_q       <= st_d;
      axis_q     <= axis_d;
      relay_q    <= relay_d;
      steps_q    <= steps_d;
      settle_q   <= settle_d;
      first_q    <= first_d;
      ref_mag_q  <= ref_mag_d;
      ref_lead_q <= ref_lead_d;
      hi_q       <= hi_d;
      store_q    <= store_d;
    end
  end

  always_comb begin
    unique case (st_q)
      S_IDLE:                     status_o = CODE_IDLE;
      S_SHIFT, S_SETTLE, S_EVAL:  status_o = CODE_BUSY;
      S_PAUSE:                    status_o = hi_q ? CODE_HIGH : CODE_LOW;
      S_FAIL:                     status_o = CODE_FAIL;
      S_DONE:                     status_o = CODE_DONE;
      default:                    status_o = CODE_IDLE;
    endcase
  end

  assign tx_req_o    = (st_q == S_SHIFT) || (st_q == S_SETTLE) ||
                       (st_q == S_EVAL)  || (st_q == S_PAUSE);
  assign relay_o     = relay_q;
  assign relay_nxt_o = relay_d;
  assign store_o     = store_q;

  // R3: a search step leaves at least one of the two fields untouched
  p_one_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_EVAL) |->
      (relay_q[R_W-1:C_W] == $past(relay_q[R_W-1:C_W]) ||
       relay_q[C_W-1:0]   == $past(relay_q[C_W-1:0])));
  // R4: the word is frozen while paused
  p_pause_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PAUSE && $past(st_q) == S_PAUSE) |-> $stable(relay_q));
  // R5: the store request lasts one clock
  p_store_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |=> !store_o);
  // R10: a start request does not disturb an active search
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SETTLE && start_i) |=> $stable(relay_q));
endmodule

// File: rtl/antenna_tune_seq.sv
module antenna_tune_seq #(
  parameter int L_W        = 15,
  parameter int C_W        = 15,
  parameter int FRAME_W    = 32,
  parameter int SETTLE_CYC = 8,
  parameter int STEP_MAX   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [L_W+C_W-1:0]   preset_i,
  input  logic                 imp_low_i,
  input  logic                 cur_lead_i,
  input  logic                 swr_ok_i,
  input  logic                 drive_low_i,
  input  logic                 drive_high_i,
  output logic [L_W+C_W-1:0]   relay_word_o,
  output logic                 ser_data_o,
  output logic                 ser_clk_o,
  output logic                 ser_latch_o,
  output logic                 ser_oe_o,
  output logic                 tx_req_o,
  output logic [2:0]           status_o,
  output logic                 store_o
);
  localparam int R_W = L_W + C_W;
  localparam int PAD = FRAME_W - R_W;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic               ser_go, ser_latch, ser_busy;
  logic [R_W-1:0]     relay_nxt;
  logic [FRAME_W-1:0] frame;

  assign frame = {{PAD{1'b0}}, relay_nxt};

  atune_ctrl #(
    .L_W(L_W), .C_W(C_W), .SETTLE_CYC(SETTLE_CYC), .STEP_MAX(STEP_MAX)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .preset_i(preset_i),
    .imp_low_i(imp_low_i), .cur_lead_i(cur_lead_i), .swr_ok_i(swr_ok_i),
    .drv_low_i(drive_low_i), .drv_high_i(drive_high_i),
    .ser_latch_i(ser_latch), .ser_go_o(ser_go), .relay_nxt_o(relay_nxt),
    .relay_o(relay_word_o), .tx_req_o(tx_req_o), .status_o(status_o),
    .store_o(store_o));

  atune_ser #(.FRAME_W(FRAME_W)) u_ser (
    .clk(clk), .rst_n(rst_int_n), .go_i(ser_go), .frame_i(frame),
    .sdat_o(ser_data_o), .sclk_o(ser_clk_o), .latch_o(ser_latch),
    .oe_o(ser_oe_o), .busy_o(ser_busy));

  assign ser_latch_o = ser_latch;

  // R1: every frame goes out while the transmit request is held
  p_tx_during_frame_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    ser_busy |-> tx_req_o);
  // R5: the store request is only raised when the search has ended
  p_store_idle_tx_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    store_o |-> !tx_req_o);
endmodule

// File: tb/antenna_tune_seq_tb.sv
module antenna_tune_seq_tb;
  localparam int CLK_NS   = 10;
  localparam int LW       = 15;
  localparam int CW       = 15;
  localparam int SETTLE   = 4;
  localparam int STEPS    = 6;
  localparam int LMAX     = (1 << LW) - 1;
  localparam int CMAX     = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [29:0] preset_i = '0;
  logic        imp_low_i, cur_lead_i, swr_ok_i;
  logic        drive_low_i = 1'b0, drive_high_i = 1'b0;
  logic [29:0] relay_word_o;
  logic        ser_data_o, ser_clk_o, ser_latch_o, ser_oe_o, tx_req_o, store_o;
  logic [2:0]  status_o;

  // bench antenna
  int lt = 0, ct = 0, force_mag = -1, force_lead = -1;
  bit no_match = 1'b0;

  always_comb begin
    imp_low_i  = (force_mag >= 0)  ? (force_mag != 0)  : (int'(relay_word_o[29:15]) >= lt);
    cur_lead_i = (force_lead >= 0) ? (force_lead != 0) : (int'(relay_word_o[14:0]) > ct);
    swr_ok_i   = !no_match && int'(relay_word_o[29:15]) == lt && int'(relay_word_o[14:0]) == ct;
  end

  antenna_tune_seq #(.L_W(LW), .C_W(CW), .FRAME_W(32), .SETTLE_CYC(SETTLE), .STEP_MAX(STEPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .preset_i(preset_i),
    .imp_low_i(imp_low_i), .cur_lead_i(cur_lead_i), .swr_ok_i(swr_ok_i),
    .drive_low_i(drive_low_i), .drive_high_i(drive_high_i),
    .relay_word_o(relay_word_o), .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o),
    .ser_latch_o(ser_latch_o), .ser_oe_o(ser_oe_o), .tx_req_o(tx_req_o),
    .status_o(status_o), .store_o(store_o));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, stores = 0, exp_fin = 0;
  logic [29:0] exp_q[$];
  logic [29:0] last_w = '0;
  logic [31:0] shreg = '0;
  int nbits = 0;
  bit oe_due = 1'b0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit m_mag(input logic [29:0] w);
    return (force_mag >= 0) ? (force_mag != 0) : (int'(w[29:15]) >= lt);
  endfunction
  function automatic bit m_lead(input logic [29:0] w);
    return (force_lead >= 0) ? (force_lead != 0) : (int'(w[14:0]) > ct);
  endfunction
  function automatic bit m_swr(input logic [29:0] w);
    return !no_match && int'(w[29:15]) == lt && int'(w[14:0]) == ct;
  endfunction

  // behavioural model of the search: list of words and final code
  task automatic predict(input logic [29:0] pre);
    logic [29:0] w = pre;
    int steps = 0;
    bit cap_turn = 1'b0, first = 1'b1, rm = 1'b0, rl = 1'b0, m, l;
    int f;
    exp_q.delete();
    if (pre != relay_word_o) exp_q.push_back(pre);
    exp_fin = 4;
    for (int i = 0; i < 200; i++) begin
      m = m_mag(w); l = m_lead(w);
      if (m_swr(w)) begin exp_fin = 5; return; end
      if (!first && m != rm && l != rl) return;
      if (steps == STEPS) return;
      if (!cap_turn) begin
        f = int'(w[29:15]);
        if (!m) begin if (f == LMAX) return; f++; end
        else begin if (f == 0) return; f--; end
        w[29:15] = f[14:0];
      end else begin
        f = int'(w[14:0]);
        if (!l) begin if (f == CMAX) return; f++; end
        else begin if (f == 0) return; f--; end
        w[14:0] = f[14:0];
      end
      if (first) begin rm = m; rl = l; first = 1'b0; end
      exp_q.push_back(w);
      steps++;
      cap_turn = !cap_turn;
    end
  endtask

  // per-clock monitor
  always @(negedge clk) begin
    cycles++;
    if (mon_on) begin
      if (relay_word_o !== last_w) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R3", "unexpected word change", {2'b00, relay_word_o}, {2'b00, last_w});
        else
          chk(relay_word_o === exp_q[0], "R3", "word sequence", {2'b00, relay_word_o}, {2'b00, exp_q[0]});
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        last_w = relay_word_o;
      end
      if (tx_req_o)
        chk(status_o inside {3'd1, 3'd2, 3'd3}, "R1", "status while searching", {29'd0, status_o}, 32'd1);
      if (store_o) stores++;
      if (oe_due) begin
        chk(ser_oe_o === 1'b1, "R2", "output enable after latch", {31'd0, ser_oe_o}, 32'd1);
        oe_due = 1'b0;
      end
      if (ser_clk_o) begin
        shreg = {shreg[30:0], ser_data_o};
        nbits++;
      end
      if (ser_latch_o) begin
        chk(nbits == 32, "R2", "bits per frame", nbits, 32);
        chk(shreg === {2'b00, relay_word_o}, "R2", "frame content", shreg, {2'b00, relay_word_o});
        nbits = 0;
        oe_due = 1'b1;
      end
    end
  end

  initial begin
    #(CLK_NS * 150000);
    chk(1'b0, "R1", "watchdog expired", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic launch(input logic [29:0] pre);
    predict(pre);
    stores = 0;
    @(negedge clk);
    preset_i = pre;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_run(input string req);
    int n = 0;
    while (!(status_o inside {3'd4, 3'd5}) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    chk(status_o == exp_fin[2:0], req, "final status", {29'd0, status_o}, exp_fin);
    chk(exp_q.size() == 0, req, "all predicted words seen", exp_q.size(), 0);
    chk(stores == ((exp_fin == 5) ? 1 : 0), "R5", "store pulses", stores, (exp_fin == 5) ? 1 : 0);
    chk(tx_req_o == 1'b0, "R5", "transmit request dropped", {31'd0, tx_req_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    chk(status_o == 3'd0, "R9", "status", {29'd0, status_o}, 0);
    chk(relay_word_o == '0, "R9", "word", {2'b00, relay_word_o}, 0);
    chk({tx_req_o, store_o, ser_latch_o, ser_clk_o, ser_oe_o} == 5'd0, "R9", "control outputs",
        {27'd0, tx_req_o, store_o, ser_latch_o, ser_clk_o, ser_oe_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    // R1 R3 R5: converging search
    lt = 103; ct = 198;
    launch({15'd100, 15'd200});
    repeat (2) @(negedge clk);
    chk(status_o == 3'd1 && tx_req_o, "R1", "searching after start", {28'd0, tx_req_o, status_o}, 32'h9);
    finish_run("R5");

    // R6: both flags flip with no match
    no_match = 1'b1; lt = 500; ct = 40;
    launch({15'd499, 15'd41});
    finish_run("R6");

    // R7: step budget runs out
    no_match = 1'b0; lt = 100; ct = 100;
    launch({15'd10, 15'd300});
    finish_run("R7");

    // R8: inductor field at all ones asked to rise
    force_mag = 0;
    launch({15'h7fff, 15'd7});
    finish_run("R8");
    chk(relay_word_o == {15'h7fff, 15'd7}, "R8", "word held at end", {2'b00, relay_word_o}, {2'b00, 15'h7fff, 15'd7});

    // R8: capacitor field at zero asked to fall
    force_lead = 1;
    launch({15'd20, 15'd0});
    finish_run("R8");
    chk(relay_word_o == {15'd21, 15'd0}, "R8", "capacitor held at zero", {2'b00, relay_word_o}, {2'b00, 15'd21, 15'd0});
    force_mag = -1; force_lead = -1;

    // R4 R10: pause on drive, ignored start, resume
    lt = 50; ct = 60;
    drive_low_i = 1'b1; drive_high_i = 1'b1;
    launch({15'd49, 15'd60});
    repeat (120) @(negedge clk);
    chk(status_o == 3'd2, "R4", "drive-low pause code", {29'd0, status_o}, 2);
    chk(tx_req_o == 1'b1, "R4", "request held in pause", {31'd0, tx_req_o}, 1);
    chk(relay_word_o == {15'd49, 15'd60}, "R4", "word frozen", {2'b00, relay_word_o}, {2'b00, 15'd49, 15'd60});
    @(negedge clk); preset_i = {15'd1, 15'd1}; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(relay_word_o == {15'd49, 15'd60}, "R10", "start ignored in pause", {2'b00, relay_word_o}, {2'b00, 15'd49, 15'd60});
    drive_low_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(status_o == 3'd3, "R4", "drive-high pause code", {29'd0, status_o}, 3);
    drive_high_i = 1'b0;
    finish_run("R4");

    // R1: restart from done
    lt = 300; ct = 300;
    launch({15'd301, 15'd299});
    finish_run("R3");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule